// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block is one DMA channel whose whole behaviour comes from a transfer descriptor. The descriptor holds a source pointer and a destination pointer, each with a signed 16-bit step and an attribute byte. The attribute byte gives the access width and an optional circular-buffer size. The descriptor also holds a byte-count word, which may carry a signed offset applied after each minor loop. The rest is a pair of iteration counters (current and starting), two end-of-major-loop adjustments and four control bits. Software loads a descriptor through the `cfg_*` inputs while the channel is idle, then arms the channel. After that, each pulse on `svc_req` moves one minor loop of bytes across a single-port memory master.

For each minor loop the engine reads enough source beats to fill one unit of the larger of the two access widths. It then writes that unit out as destination beats, and repeats until the byte count is used up. After the last write it applies the minor-loop offset and counts the iteration down. When the count runs out it applies the end adjustments, reloads the counter and sets `done`. If scatter-gather is enabled it then fetches a replacement descriptor from memory. Optional single-cycle events mark the half-way point and the end of the major loop. A bad descriptor raises `cfg_err`, and the request that found it moves nothing.

Top module: `desc_dma_engine`

## Requirements
- R1: After reset, `busy`, `done`, `armed`, `cfg_err`, `half_evt`, `major_evt` and `mem_req` are all 0.
- R2: `svc_req` has no effect unless `armed` is 1. `arm` sets `armed`. `cfg_load` is accepted only while `busy` is 0. It loads every descriptor field, sets both iteration counters to `cfg_iter`, and clears `done` and `cfg_err`.
- R3: Attribute bits [2:0] select the access width: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes. `mem_size` carries that code. Data is right-justified and little-endian on `mem_rdata`/`mem_wdata`. Within a minor loop, each unit of the larger width is built from consecutive source reads (first read in the lowest bytes) and then written out as consecutive destination writes, lowest bytes first.
- R4: After every source read the sign-extended 16-bit source step is added to the source pointer. After every destination write the destination step is added to the destination pointer. A step of 0 keeps the pointer fixed.
- R5: Attribute bits [7:3] hold M. When M is nonzero, only pointer bits [M-1:0] take the stepped value and the upper bits are kept, so the pointer wraps inside an aligned 2^M-byte buffer.
- R6: One accepted request moves exactly the minor-loop byte count, then decrements the current iteration count by one.
- R7: When byte-count word bit 31 (source) or bit 30 (destination) is set, bits [9:0] are the byte count and bits [29:10] are a signed offset. After the minor loop that offset is added to each enabled pointer. When neither bit is set, bits [29:0] are the byte count.
- R8: When the count reaches zero, the 32-bit source adjustment is added to the source pointer. The destination adjustment is added to the destination pointer unless scatter-gather is on. The current count reloads from the starting count and `done` is set. If control bit 0 is set, `major_evt` pulses for one cycle.
- R9: If control bit 1 is set, `half_evt` pulses for one cycle when a decrement leaves the current count equal to the starting count shifted right by one, provided the starting count is at least 2.
- R10: If control bit 2 is set, completing the major loop clears `armed`. Otherwise the channel stays armed.
- R11: If control bit 3 is set, completing the major loop fetches eight 32-bit words from the destination adjustment with its low five bits cleared, and these words replace the descriptor. Layout:
  - word 0: source pointer
  - word 1: source step in [15:0], source attribute in [23:16], destination attribute in [31:24]
  - word 2: byte-count word
  - word 3: source adjustment
  - word 4: destination pointer
  - word 5: destination step in [15:0], iteration count in [30:16]
  - word 6: destination adjustment
  - word 7: control bits in [3:0]
- R12: A request finds the descriptor bad when any of these holds: a width code above 2, a byte count of 0, a byte count that is not a multiple of the larger width, or an iteration count of 0. It then sets `cfg_err`, makes no memory access and changes no pointer or counter.
- R13: `done` clears on `done_clr` or `cfg_load`. `busy` is 1 from the cycle after an accepted request until the minor loop and any descriptor fetch end.
- R14: While `mem_req` is 1 and `mem_ready` is 0, the request, address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load descriptor fields (idle only) |
| cfg_saddr | input | 32 | Source pointer |
| cfg_soff | input | 16 | Signed source step |
| cfg_sattr | input | 8 | Source attribute: [7:3] modulo, [2:0] width |
| cfg_nbytes | input | 32 | Byte-count word with optional minor-loop offset |
| cfg_slast | input | 32 | Source adjustment at major end |
| cfg_daddr | input | 32 | Destination pointer |
| cfg_doff | input | 16 | Signed destination step |
| cfg_dattr | input | 8 | Destination attribute: [7:3] modulo, [2:0] width |
| cfg_iter | input | IW | Iteration count (starting and current) |
| cfg_dlast | input | 32 | Destination adjustment or next-descriptor address |
| cfg_ctrl | input | 4 | [0] major event, [1] half event, [2] auto-disarm, [3] scatter-gather |
| arm | input | 1 | Set the armed state |
| done_clr | input | 1 | Clear the done flag |
| svc_req | input | 1 | Service request: run one minor loop |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Right-justified write data |
| mem_ready | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Right-justified read data, valid with mem_ready |
| busy | output | 1 | Minor loop or descriptor fetch in progress |
| done | output | 1 | Major loop completed |
| armed | output | 1 | Requests are accepted |
| cfg_err | output | 1 | Last request found a bad descriptor |
| half_evt | output | 1 | Half-way event pulse |
| major_evt | output | 1 | Major-loop completion event pulse |
| cur_saddr | output | 32 | Current source pointer |
| cur_daddr | output | 32 | Current destination pointer |
| cur_iter | output | IW | Current iteration count |

## Verification
The hardest state to reach from the ports is a major-loop end that chains into a scatter-gather fetch. It needs a descriptor already sitting in memory, an unaligned next-descriptor address, and the adjustment, counter-reload and event logic all firing in the same cycle as the fetch starts. Directed cases place such a descriptor in memory, run into it and then keep servicing under the new descriptor. A byte-level bench model predicts the pointers, counters, event counts and the whole memory image. Seeded random descriptors mix all width pairs, wrapping steps and minor-loop offsets. Random stalls on `mem_ready` hold accesses pending in every phase.

// File: rtl/desc_dma_engine.sv
module desc_dma_engine #(
  parameter int IW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [31:0]   cfg_saddr,
  input  logic [15:0]   cfg_soff,
  input  logic [7:0]    cfg_sattr,
  input  logic [31:0]   cfg_nbytes,
  input  logic [31:0]   cfg_slast,
  input  logic [31:0]   cfg_daddr,
  input  logic [15:0]   cfg_doff,
  input  logic [7:0]    cfg_dattr,
  input  logic [IW-1:0] cfg_iter,
  input  logic [31:0]   cfg_dlast,
  input  logic [3:0]    cfg_ctrl,
  input  logic          arm,
  input  logic          done_clr,
  input  logic          svc_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          armed,
  output logic          cfg_err,
  output logic          half_evt,
  output logic          major_evt,
  output logic [31:0]   cur_saddr,
  output logic [31:0]   cur_daddr,
  output logic [IW-1:0] cur_iter
);
  localparam int CW = 30;
  localparam int SGW = 8;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_FIN, S_SG} st_t;
  st_t st;

  logic [31:0] saddr, daddr, nbw, slast, dlast, sg_base, pk;
  logic [15:0] soff, doff;
  logic [7:0]  sattr, dattr;
  logic [IW-1:0] citer, biter;
  logic [3:0]  ctrl;
  logic [2:0]  roff, woff;
  logic [CW-1:0] left;
  logic [$clog2(SGW)-1:0] sg_cnt;

  function automatic logic [31:0] step(input logic [31:0] a, input logic [15:0] off,
                                       input logic [4:0] m);
    logic [31:0] s, msk;
    s   = a + {{16{off[15]}}, off};
    msk = (32'd1 << m) - 32'd1;
    return (m == 5'd0) ? s : ((a & ~msk) | (s & msk));
  endfunction

  wire [2:0]    sbytes = 3'd1 << sattr[1:0];
  wire [2:0]    dbytes = 3'd1 << dattr[1:0];
  wire [2:0]    big    = (sbytes > dbytes) ? sbytes : dbytes;
  wire          mlo    = nbw[31] | nbw[30];
  wire [CW-1:0] nbytes = mlo ? CW'(nbw[9:0]) : nbw[CW-1:0];
  wire [31:0]   mloff  = {{12{nbw[29]}}, nbw[29:10]};
  wire [31:0]   smask  = ~(32'hFFFF_FFFF << {sbytes, 3'b000});
  wire [31:0]   dmask  = ~(32'hFFFF_FFFF << {dbytes, 3'b000});
  wire [IW-1:0] citer_dec = citer - 1'b1;
  wire          bad = (sattr[2:0] > 3'd2) || (dattr[2:0] > 3'd2) || (nbytes == '0) ||
                      ((nbytes & CW'(big - 3'd1)) != '0) || (citer == '0) || (biter == '0);
  wire [31:0]   s_add = (nbw[31] ? mloff : 32'd0) + ((citer_dec == '0) ? slast : 32'd0);
  wire [31:0]   d_add = (nbw[30] ? mloff : 32'd0) +
                        ((citer_dec == '0 && !ctrl[3]) ? dlast : 32'd0);

  assign mem_req   = (st == S_RD) || (st == S_WR) || (st == S_SG);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? daddr :
                     (st == S_SG) ? (sg_base + {27'd0, sg_cnt, 2'b00}) : saddr;
  assign mem_size  = (st == S_WR) ? dattr[1:0] : (st == S_SG) ? 2'd2 : sattr[1:0];
  assign mem_wdata = (pk >> {woff, 3'b000}) & dmask;
  assign busy      = (st != S_IDLE);
  assign cur_saddr = saddr;
  assign cur_daddr = daddr;
  assign cur_iter  = citer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      saddr <= '0; daddr <= '0; nbw <= '0; slast <= '0; dlast <= '0;
      soff <= '0; doff <= '0; sattr <= '0; dattr <= '0; ctrl <= '0;
      citer <= '0; biter <= '0; sg_base <= '0; pk <= '0;
      roff <= '0; woff <= '0; left <= '0; sg_cnt <= '0;
      done <= 1'b0; armed <= 1'b0; cfg_err <= 1'b0;
      half_evt <= 1'b0; major_evt <= 1'b0;
    end else begin
      half_evt  <= 1'b0;
      major_evt <= 1'b0;
      if (arm) armed <= 1'b1;
      if (done_clr) done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cfg_load) begin
            saddr <= cfg_saddr; soff <= cfg_soff; sattr <= cfg_sattr;
            nbw <= cfg_nbytes; slast <= cfg_slast;
            daddr <= cfg_daddr; doff <= cfg_doff; dattr <= cfg_dattr;
            dlast <= cfg_dlast; ctrl <= cfg_ctrl;
            citer <= cfg_iter; biter <= cfg_iter;
            done <= 1'b0; cfg_err <= 1'b0;
          end else if (svc_req && armed) begin
            if (bad) cfg_err <= 1'b1;
            else begin
              st <= S_RD; left <= nbytes;
              roff <= '0; woff <= '0; pk <= '0;
            end
          end
        end
        S_RD: if (mem_ready) begin
          pk    <= pk | ((mem_rdata & smask) << {roff, 3'b000});
          saddr <= step(saddr, soff, sattr[7:3]);
          if (roff + sbytes == big) begin
            st <= S_WR; woff <= '0;
          end else roff <= roff + sbytes;
        end
        S_WR: if (mem_ready) begin
          daddr <= step(daddr, doff, dattr[7:3]);
          if (woff + dbytes == big) begin
            if (left == CW'(big)) st <= S_FIN;
            else begin
              st <= S_RD; left <= left - CW'(big); roff <= '0; pk <= '0;
            end
          end else woff <= woff + dbytes;
        end
        S_FIN: begin
          saddr <= saddr + s_add;
          daddr <= daddr + d_add;
          if (citer_dec == '0) begin
            citer     <= biter;
            done      <= 1'b1;
            major_evt <= ctrl[0];
            if (ctrl[2]) armed <= 1'b0;
            if (ctrl[3]) begin
              st <= S_SG; sg_cnt <= '0; sg_base <= {dlast[31:5], 5'd0};
            end else st <= S_IDLE;
          end else begin
            citer    <= citer_dec;
            half_evt <= ctrl[1] && (biter >= IW'(2)) && (citer_dec == (biter >> 1));
            st       <= S_IDLE;
          end
        end
        S_SG: if (mem_ready) begin
          case (sg_cnt)
            3'd0: saddr <= mem_rdata;
            3'd1: begin soff <= mem_rdata[15:0]; sattr <= mem_rdata[23:16];
                        dattr <= mem_rdata[31:24]; end
            3'd2: nbw <= mem_rdata;
            3'd3: slast <= mem_rdata;
            3'd4: daddr <= mem_rdata;
            3'd5: begin doff <= mem_rdata[15:0]; citer <= mem_rdata[16 +: IW];
                        biter <= mem_rdata[16 +: IW]; end
            3'd6: dlast <= mem_rdata;
            default: ctrl <= mem_rdata[3:0];
          endcase
          if (sg_cnt == 3'(SGW - 1)) st <= S_IDLE;
          else sg_cnt <= sg_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_dma_engine_chk.sv
module desc_dma_engine_chk #(
  parameter int IW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          mem_req,
  input logic          mem_we,
  input logic [31:0]   mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ready,
  input logic          busy,
  input logic          done,
  input logic          cfg_err,
  input logic          half_evt,
  input logic          major_evt,
  input logic [31:0]   cur_saddr,
  input logic [IW-1:0] cur_iter
);
  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  p_major_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    major_evt |-> done);

  p_evt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_evt && major_evt));

  p_iter_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_iter != '0);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) && !$past(cfg_load) |-> $stable(cur_saddr));

  p_req_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

bind desc_dma_engine desc_dma_engine_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .busy(busy),
  .done(done), .cfg_err(cfg_err), .half_evt(half_evt), .major_evt(major_evt),
  .cur_saddr(cur_saddr), .cur_iter(cur_iter)
);

// File: tb/desc_dma_engine_bench.sv
module desc_dma_engine_bench;
  localparam int IW = 15;
  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, arm = 0, done_clr = 0, svc_req = 0;
  logic [31:0] cfg_saddr = 0, cfg_nbytes = 0, cfg_slast = 0, cfg_daddr = 0, cfg_dlast = 0;
  logic [15:0] cfg_soff = 0, cfg_doff = 0;
  logic [7:0]  cfg_sattr = 0, cfg_dattr = 0;
  logic [IW-1:0] cfg_iter = 0;
  logic [3:0]  cfg_ctrl = 0;
  logic mem_req, mem_we, mem_ready = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic busy, done, armed, cfg_err, half_evt, major_evt;
  logic [31:0] cur_saddr, cur_daddr;
  logic [IW-1:0] cur_iter;

  always #4 clk = ~clk;

  desc_dma_engine #(.IW(IW)) u_desc_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_saddr(cfg_saddr), .cfg_soff(cfg_soff),
    .cfg_sattr(cfg_sattr), .cfg_nbytes(cfg_nbytes), .cfg_slast(cfg_slast), .cfg_daddr(cfg_daddr),
    .cfg_doff(cfg_doff), .cfg_dattr(cfg_dattr), .cfg_iter(cfg_iter), .cfg_dlast(cfg_dlast),
    .cfg_ctrl(cfg_ctrl), .arm(arm), .done_clr(done_clr), .svc_req(svc_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .armed(armed), .cfg_err(cfg_err), .half_evt(half_evt),
    .major_evt(major_evt), .cur_saddr(cur_saddr), .cur_daddr(cur_daddr), .cur_iter(cur_iter));

  logic [7:0] mem [0:4095];
  logic [7:0] smem [0:4095];
  assign mem_rdata = {mem[12'(mem_addr + 32'd3)], mem[12'(mem_addr + 32'd2)],
                      mem[12'(mem_addr + 32'd1)], mem[12'(mem_addr)]};

  always @(posedge clk)
    if (mem_req && mem_we && mem_ready)
      for (int k = 0; k < (1 << mem_size); k++)
        mem[12'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];

  always @(negedge clk) mem_ready <= ($urandom_range(3) != 0);

  int checks = 0, errors = 0, cyc = 0, hcnt = 0, mcnt = 0;
  always @(posedge clk) begin
    if (half_evt) hcnt++;
    if (major_evt) mcnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bench model of the descriptor
  logic [31:0] m_saddr, m_daddr, m_nbw, m_slast, m_dlast;
  logic [15:0] m_soff, m_doff;
  logic [7:0]  m_sattr, m_dattr;
  logic [IW-1:0] m_citer, m_biter;
  logic [3:0]  m_ctrl;
  bit m_done = 0, m_armed = 0, m_err = 0, m_moved = 0;
  int m_hcnt = 0, m_mcnt = 0;

  function automatic logic [31:0] nxt(input logic [31:0] a, input logic [15:0] off, input logic [4:0] m);
    logic [31:0] s, msk;
    s = a + {{16{off[15]}}, off};
    if (m == 0) return s;
    msk = (32'd1 << m) - 32'd1;
    return (a & ~msk) | (s & msk);
  endfunction

  function automatic logic [31:0] srd32(input logic [31:0] a);
    return {smem[12'(a + 3)], smem[12'(a + 2)], smem[12'(a + 1)], smem[12'(a)]};
  endfunction

  task automatic m_service();
    int sb, db, bg, nb;
    logic [31:0] pk, ml, base;
    m_moved = 0;
    if (!m_armed) return;
    sb = 1 << m_sattr[1:0];
    db = 1 << m_dattr[1:0];
    bg = (sb > db) ? sb : db;
    nb = (m_nbw[31] || m_nbw[30]) ? int'(m_nbw[9:0]) : int'(m_nbw[29:0]);
    if (m_sattr[2:0] > 2 || m_dattr[2:0] > 2 || nb == 0 || nb % bg != 0 || m_citer == 0) begin
      m_err = 1;
      return;
    end
    m_moved = 1;
    for (int c = 0; c < nb / bg; c++) begin
      pk = 0;
      for (int r = 0; r < bg / sb; r++) begin
        for (int k = 0; k < sb; k++) pk[8*(r*sb+k) +: 8] = smem[12'(m_saddr + 32'(k))];
        m_saddr = nxt(m_saddr, m_soff, m_sattr[7:3]);
      end
      for (int w = 0; w < bg / db; w++) begin
        for (int k = 0; k < db; k++) smem[12'(m_daddr + 32'(k))] = pk[8*(w*db+k) +: 8];
        m_daddr = nxt(m_daddr, m_doff, m_dattr[7:3]);
      end
    end
    ml = {{12{m_nbw[29]}}, m_nbw[29:10]};
    if (m_nbw[31]) m_saddr += ml;
    if (m_nbw[30]) m_daddr += ml;
    if (m_citer == 1) begin
      m_saddr += m_slast;
      if (!m_ctrl[3]) m_daddr += m_dlast;
      m_citer = m_biter;
      m_done = 1;
      if (m_ctrl[0]) m_mcnt++;
      if (m_ctrl[2]) m_armed = 0;
      if (m_ctrl[3]) begin
        base = {m_dlast[31:5], 5'd0};
        m_saddr = srd32(base);
        {m_dattr, m_sattr, m_soff} = srd32(base + 4);
        m_nbw = srd32(base + 8);
        m_slast = srd32(base + 12);
        m_daddr = srd32(base + 16);
        m_doff = srd32(base + 20) & 32'hFFFF;
        m_citer = srd32(base + 20) >> 16;
        m_biter = m_citer;
        m_dlast = srd32(base + 24);
        m_ctrl = srd32(base + 28) & 32'hF;
      end
    end else begin
      m_citer--;
      if (m_ctrl[1] && m_biter >= 2 && m_citer == (m_biter >> 1)) m_hcnt++;
    end
  endtask

  task automatic poke32(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) begin
      mem[12'(a + 32'(k))] = v[8*k +: 8];
      smem[12'(a + 32'(k))] = v[8*k +: 8];
    end
  endtask

  task automatic load_desc(input logic [31:0] sa, input logic [15:0] so, input logic [7:0] sat,
                           input logic [31:0] nbw, input logic [31:0] sl, input logic [31:0] da,
                           input logic [15:0] dof, input logic [7:0] dat, input logic [IW-1:0] it,
                           input logic [31:0] dl, input logic [3:0] ct);
    @(negedge clk);
    cfg_saddr = sa; cfg_soff = so; cfg_sattr = sat; cfg_nbytes = nbw; cfg_slast = sl;
    cfg_daddr = da; cfg_doff = dof; cfg_dattr = dat; cfg_iter = it; cfg_dlast = dl; cfg_ctrl = ct;
    cfg_load = 1;
    @(negedge clk) cfg_load = 0;
    m_saddr = sa; m_soff = so; m_sattr = sat; m_nbw = nbw; m_slast = sl;
    m_daddr = da; m_doff = dof; m_dattr = dat; m_citer = it; m_biter = it;
    m_dlast = dl; m_ctrl = ct; m_done = 0; m_err = 0;
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1;
    @(negedge clk) arm = 0;
    m_armed = 1;
  endtask

  task automatic svc_check(input string tag);
    bit saw_busy = 0;
    int bad = 0;
    @(negedge clk) svc_req = 1;
    @(negedge clk) svc_req = 0;
    while (busy) begin saw_busy = 1; @(negedge clk); end
    @(negedge clk);
    m_service();
    chk(cur_saddr == m_saddr, {tag, " source pointer"}, cur_saddr, m_saddr);
    chk(cur_daddr == m_daddr, {tag, " destination pointer"}, cur_daddr, m_daddr);
    chk(cur_iter == m_citer, {tag, " iteration R6"}, 32'(cur_iter), 32'(m_citer));
    chk(done == m_done, {tag, " done R8"}, 32'(done), 32'(m_done));
    chk(armed == m_armed, {tag, " armed R10"}, 32'(armed), 32'(m_armed));
    chk(cfg_err == m_err, {tag, " error R12"}, 32'(cfg_err), 32'(m_err));
    chk(saw_busy == m_moved, {tag, " busy R13"}, 32'(saw_busy), 32'(m_moved));
    chk(hcnt == m_hcnt, {tag, " half events R9"}, 32'(hcnt), 32'(m_hcnt));
    chk(mcnt == m_mcnt, {tag, " major events R8"}, 32'(mcnt), 32'(m_mcnt));
    for (int i = 0; i < 4096; i++) if (mem[i] !== smem[i]) bad++;
    chk(bad == 0, {tag, " memory image R3"}, 32'(bad), 0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'($urandom);
      smem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && armed == 0, "R1 reset flags", {busy, done, armed}, 0);
    chk(cfg_err == 0 && half_evt == 0 && major_evt == 0 && mem_req == 0, "R1 reset outputs",
        {cfg_err, half_evt, major_evt, mem_req}, 0);
    @(negedge clk) rst_n = 1;

    // byte buffer to fixed destination; request while unarmed is ignored
    load_desc(32'h100, 16'd1, 8'h00, 32'd2, -32'sd6, 32'h800, 16'd0, 8'h00, 15'd3, 32'd0, 4'b0001);
    svc_check("R2 unarmed request");
    do_arm();
    for (int i = 0; i < 3; i++) svc_check("R4 byte buffer");

    // 16-bit source into 32-bit destination
    load_desc(32'h200, 16'd2, 8'h01, 32'd8, 32'd0, 32'h900, 16'd4, 8'h02, 15'd2, -32'sd16, 4'b0001);
    for (int i = 0; i < 2; i++) svc_check("R3 width mix");

    // circular source of 8 bytes starting mid-buffer
    load_desc(32'h105, 16'd1, 8'h18, 32'd4, 32'd0, 32'hA00, 16'd1, 8'h00, 15'd4, 32'd0, 4'b0000);
    for (int i = 0; i < 4; i++) svc_check("R5 modulo wrap");

    // minor-loop offset on both pointers (-4 in bits 29:10)
    load_desc(32'h300, 16'd1, 8'h00, {2'b11, 20'hFFFFC, 10'd4}, 32'd0, 32'hB00, 16'd1, 8'h00,
              15'd3, 32'd0, 4'b0000);
    for (int i = 0; i < 3; i++) svc_check("R7 minor offset");

    // half and major events with auto-disarm
    load_desc(32'h400, 16'd2, 8'h01, 32'd4, -32'sd32, 32'hC00, 16'd2, 8'h01, 15'd4, 32'd0, 4'b0111);
    for (int i = 0; i < 5; i++) svc_check("R9 R10 events");

    // done clear
    @(negedge clk) done_clr = 1;
    @(negedge clk) done_clr = 0;
    m_done = 0;
    chk(done == 0, "R13 done clear", 32'(done), 0);

    // bad byte count: not a multiple of 2
    load_desc(32'h500, 16'd2, 8'h01, 32'd3, 32'd0, 32'hD00, 16'd1, 8'h00, 15'd2, 32'd0, 4'b0000);
    do_arm();
    svc_check("R12 bad count");
    load_desc(32'h500, 16'd2, 8'h03, 32'd4, 32'd0, 32'hD00, 16'd1, 8'h00, 15'd2, 32'd0, 4'b0000);
    svc_check("R12 bad width");
    load_desc(32'h500, 16'd2, 8'h01, 32'd4, 32'd0, 32'hD00, 16'd1, 8'h00, 15'd2, 32'd0, 4'b0000);
    chk(cfg_err == 0, "R2 load clears error", 32'(cfg_err), 0);
    svc_check("R12 recovered");

    // scatter-gather chain: next descriptor at 0x300 addressed as 0x310
    poke32(32'h300, 32'h040);
    poke32(32'h304, {8'h00, 8'h00, 16'd1});
    poke32(32'h308, 32'd2);
    poke32(32'h30C, 32'd0);
    poke32(32'h310, 32'hE00);
    poke32(32'h314, {1'b0, 15'd2, 16'd1});
    poke32(32'h318, 32'd0);
    poke32(32'h31C, 32'h1);
    load_desc(32'h600, 16'd1, 8'h00, 32'd2, 32'd0, 32'hF00, 16'd1, 8'h00, 15'd1, 32'h310, 4'b1001);
    svc_check("R11 gather fetch");
    for (int i = 0; i < 2; i++) svc_check("R11 after reload");

    // seeded random descriptors with memory stalls
    for (int d = 0; d < 30; d++) begin
      logic [1:0] sw, dw;
      logic [4:0] sm, dm;
      int bg, nb;
      logic [31:0] nbw;
      sw = 2'($urandom_range(2));
      dw = 2'($urandom_range(2));
      sm = ($urandom_range(3) == 0) ? 5'($urandom_range(6, 3)) : 5'd0;
      dm = ($urandom_range(3) == 0) ? 5'($urandom_range(6, 3)) : 5'd0;
      bg = 1 << ((sw > dw) ? sw : dw);
      nb = bg * $urandom_range(4, 1);
      if ($urandom_range(3) == 0)
        nbw = {1'($urandom), 1'($urandom), 20'($signed($urandom_range(16)) - 8), 10'(nb)};
      else nbw = 32'(nb);
      load_desc(32'($urandom_range(4095)), 16'(1 << sw) * 16'($urandom_range(1)), {sm, 1'b0, sw},
                nbw, 32'($signed($urandom_range(64)) - 32), 32'($urandom_range(4095)),
                16'(1 << dw) * 16'($urandom_range(1)), {dm, 1'b0, dw}, 15'($urandom_range(5, 1)),
                32'($signed($urandom_range(64)) - 32), 4'($urandom_range(7)));
      do_arm();
      for (int s = 0; s < $urandom_range(6, 1); s++) svc_check("R14 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule